// File: doc/BRIEF.md
# DMA channel transfer engine

This block is the data-moving core of one direct-memory-access channel. Software programs a peripheral-side base address, a memory-side base address and an item count, picks a direction, a data size for each side, per-side address increment and optional circular operation, then sets the enable bit. From then on every item is moved as one read on a 32-bit bus master port followed by one write. Items are started either by a level request from the peripheral or, in memory-to-memory mode, continuously without any request.

The engine keeps private current-address and remaining-count registers, so the programmed values survive the transfer. It adapts the data width between the two sides: a narrow source is zero-extended and a wide source is truncated. Narrow writes are replicated across all byte lanes. It reports half-way, completion and bus-error events. A bus error switches the channel off in hardware. Arbitration between channels and the software flag register sit outside this block.

The bus port follows valid/ready rules. `bus_valid` rises with a stable address, direction, size and write data, and all of them stay unchanged until the slave raises `bus_ready` in a clock cycle. That cycle completes the access. The slave may hold `bus_ready` low for any number of cycles to apply back-pressure. `bus_rdata` and `bus_err` are sampled only in the completing cycle.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the channel is disabled, `bus_valid` is low, `remaining` is 0 and no event output is high.
- R2: An item starts only while the channel is enabled, `remaining` is non-zero, and either `xfer_req` is high or memory-to-memory mode (`cfg_m2m`=1) is set. A channel waiting without a request never raises `bus_valid`.
- R3: Each item is one read from the source followed by one write to the destination. With `cfg_dir`=0 the source is the peripheral side and the destination is the memory side. With `cfg_dir`=1 the sides swap.
- R4: Size codes are 00 = 8 bits, 01 = 16 bits and 10 = 32 bits, and each access presents its side's code on `bus_size`. The address has bit 0 forced to 0 for 16-bit accesses and bits 1:0 forced to 0 for 32-bit accesses.
- R5: After each item that completes without error, a side with its increment enable set advances its current address by 1, 2 or 4 bytes according to its size code. A side without it keeps the same address.
- R6: Read data arrives in the least-significant bits of `bus_rdata`. Only the narrower of the two sizes is kept, and the upper bits are zero. For an 8-bit write that byte fills all four lanes of `bus_wdata`, and for a 16-bit write the halfword fills both halves.
- R7: `remaining` drops by one per item completed without error. In non-circular operation it stops at 0, no further access is issued, and the enable bit stays set.
- R8: In circular operation, the item that brings the count to 0 reloads the count and both current addresses from the programmed values, and service continues. The programmed values never change while the channel is enabled.
- R9: When memory-to-memory mode is set, circular operation is ignored and the channel stops at 0.
- R10: Writing 0→1 to the enable bit loads the count and both current addresses from the programmed values. `prog_we` is ignored while the channel is enabled.
- R11: `evt_half` pulses for one cycle in the cycle after the item that leaves `remaining` equal to floor(N/2), where N is the programmed count. `evt_done` pulses likewise after the item that brings it to 0. For N = 1 both pulse together.
- R12: An error on either the read or the write clears the enable bit and pulses `evt_err` for one cycle in the following cycle. The item is not counted, and the addresses do not advance. A failed read is not followed by a write.
- R13: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr`, `bus_write`, `bus_size` and `bus_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Strobe that writes the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| prog_we | input | 1 | Strobe that writes the base addresses and count, honoured only while disabled |
| prog_paddr | input | 32 | Peripheral-side base address |
| prog_maddr | input | 32 | Memory-side base address |
| prog_count | input | 16 | Number of items |
| cfg_dir | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| cfg_circ | input | 1 | Circular operation |
| cfg_m2m | input | 1 | Memory-to-memory mode, items run without a request |
| cfg_psize | input | 2 | Peripheral-side size code |
| cfg_msize | input | 2 | Memory-side size code |
| cfg_pinc | input | 1 | Peripheral-side address increment enable |
| cfg_minc | input | 1 | Memory-side address increment enable |
| xfer_req | input | 1 | Peripheral request level |
| bus_valid | output | 1 | Bus access valid |
| bus_write | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | 32 | Byte address, aligned to the access size |
| bus_size | output | 2 | Size code of the access |
| bus_wdata | output | 32 | Write data, lane-replicated |
| bus_ready | input | 1 | Slave completes the access in this cycle |
| bus_rdata | input | 32 | Read data, item in the low bits |
| bus_err | input | 1 | Access failed, valid with `bus_ready` |
| chan_en | output | 1 | Current enable bit |
| remaining | output | 16 | Live remaining item count |
| evt_half | output | 1 | Half-transfer pulse |
| evt_done | output | 1 | Transfer-complete pulse |
| evt_err | output | 1 | Transfer-error pulse |

## Verification
The assertions assume that the slave holds `bus_ready`, `bus_rdata` and `bus_err` meaningful only while `bus_valid` is high. They also assume that the configuration inputs stay constant while an item is in flight, and that the enable bit is not toggled in the middle of an item. The stimulus changes configuration only while the channel is disabled and idle. It sends enable writes only while `bus_valid` is low. It drives `bus_ready` from `$urandom` with a fixed seed, so that back-pressure of varying length lands on both reads and writes. Error responses are raised only for one chosen address at a time, so every error case has a known point in the sequence.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } eng_state_e;

  // Size code to byte count: 00 -> 1, 01 -> 2, otherwise 4.
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'b00:   size_bytes = 3'd1;
      2'b01:   size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // Narrower of two size codes (reserved 11 treated as 32-bit).
  function automatic logic [1:0] size_min(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] ea;
    logic [1:0] eb;
    ea = (a == 2'b11) ? 2'b10 : a;
    eb = (b == 2'b11) ? 2'b10 : b;
    size_min = (ea < eb) ? ea : eb;
  endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_eng_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic          inc,
  input  logic [1:0]    size,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cur <= '0;
    else if (load)           cur <= base;
    else if (adv && inc)     cur <= cur + AW'(size_bytes(size));
  end

  // Low address bits forced to the access alignment.
  always_comb begin
    addr = cur;
    case (size)
      2'b00:   addr = cur;
      2'b01:   addr[0] = 1'b0;
      default: addr[1:0] = 2'b00;
    endcase
  end
endmodule

// File: rtl/dma_item_counter.sv
module dma_item_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dec,
  input  logic          wrap_en,
  input  logic [CW-1:0] prog,
  output logic [CW-1:0] live,
  output logic          zero,
  output logic          hit_half,
  output logic          hit_done,
  output logic          wrap
);
  logic [CW-1:0] after_dec;

  assign after_dec = live - 1'b1;
  assign zero      = (live == '0);
  assign hit_done  = dec && (live == CW'(1));
  assign hit_half  = dec && (after_dec == (prog >> 1));
  assign wrap      = hit_done && wrap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      live <= '0;
    else if (load)   live <= prog;
    else if (wrap)   live <= prog;
    else if (dec)    live <= after_dec;
  end
endmodule

// File: rtl/dma_width_adapt.sv
module dma_width_adapt
  import dma_eng_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] rd_item,
  input  logic [1:0]    src_size,
  input  logic [1:0]    dst_size,
  output logic [DW-1:0] wr_bus
);
  localparam int LANES  = DW / 8;
  localparam int HALVES = DW / 16;

  logic [1:0]    keep;
  logic [DW-1:0] narrowed;

  always_comb begin
    keep = size_min(src_size, dst_size);
    narrowed = '0;
    case (keep)
      2'b00:   narrowed[7:0]  = rd_item[7:0];
      2'b01:   narrowed[15:0] = rd_item[15:0];
      default: narrowed       = rd_item;
    endcase
  end

  always_comb begin
    wr_bus = narrowed;
    if (dst_size == 2'b00) begin
      for (int i = 0; i < LANES; i++) wr_bus[8*i +: 8] = narrowed[7:0];
    end else if (dst_size == 2'b01) begin
      for (int j = 0; j < HALVES; j++) wr_bus[16*j +: 16] = narrowed[15:0];
    end
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_eng_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_wr,
  input  logic          en_wdata,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_paddr,
  input  logic [AW-1:0] prog_maddr,
  input  logic [CW-1:0] prog_count,
  input  logic          cfg_dir,
  input  logic          cfg_circ,
  input  logic          cfg_m2m,
  input  logic [1:0]    cfg_psize,
  input  logic [1:0]    cfg_msize,
  input  logic          cfg_pinc,
  input  logic          cfg_minc,
  input  logic          xfer_req,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_err,
  output logic          chan_en,
  output logic [CW-1:0] remaining,
  output logic          evt_half,
  output logic          evt_done,
  output logic          evt_err
);
  eng_state_e    state, nxt;
  logic          en_q;
  logic [AW-1:0] base_p, base_m;
  logic [CW-1:0] base_n;
  logic [DW-1:0] rd_hold, adapted;
  logic [AW-1:0] p_addr, m_addr;
  logic          hs, start, rd_cap, item_ok, err_hit, en_load, circ_eff;
  logic          cnt_zero, hit_half, hit_done, wrap;
  logic [1:0]    src_sz, dst_sz;

  assign hs       = bus_valid && bus_ready;
  assign circ_eff = cfg_circ && !cfg_m2m;                       // R9
  assign en_load  = en_wr && en_wdata && !en_q;                 // R10
  assign start    = (state == ST_IDLE) && en_q && !cnt_zero && (xfer_req || cfg_m2m);
  assign src_sz   = cfg_dir ? cfg_msize : cfg_psize;
  assign dst_sz   = cfg_dir ? cfg_psize : cfg_msize;

  // Programmed values, frozen while enabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_p <= '0; base_m <= '0; base_n <= '0;
    end else if (prog_we && !en_q) begin
      base_p <= prog_paddr; base_m <= prog_maddr; base_n <= prog_count;
    end
  end

  // Enable bit: hardware clear on error wins over a software write (R12).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (err_hit) en_q <= 1'b0;
    else if (en_wr)  en_q <= en_wdata;
  end

  always_comb begin
    nxt = state; rd_cap = 1'b0; item_ok = 1'b0; err_hit = 1'b0;
    case (state)
      ST_IDLE: if (start) nxt = ST_RD;
      ST_RD: if (hs) begin
        if (bus_err) begin err_hit = 1'b1; nxt = ST_IDLE; end
        else begin rd_cap = 1'b1; nxt = ST_WR; end
      end
      ST_WR: if (hs) begin
        nxt = ST_IDLE;
        if (bus_err) err_hit = 1'b1;
        else item_ok = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; rd_hold <= '0;
      evt_half <= 1'b0; evt_done <= 1'b0; evt_err <= 1'b0;
    end else begin
      state    <= nxt;
      if (rd_cap) rd_hold <= bus_rdata;
      evt_half <= hit_half;
      evt_done <= hit_done;
      evt_err  <= err_hit;
    end
  end

  dma_addr_gen #(.AW(AW)) u_pside (
    .clk(clk), .rst_n(rst_n), .load(en_load || wrap), .adv(item_ok),
    .inc(cfg_pinc), .size(cfg_psize), .base(base_p), .addr(p_addr));

  dma_addr_gen #(.AW(AW)) u_mside (
    .clk(clk), .rst_n(rst_n), .load(en_load || wrap), .adv(item_ok),
    .inc(cfg_minc), .size(cfg_msize), .base(base_m), .addr(m_addr));

  dma_item_counter #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .load(en_load), .dec(item_ok), .wrap_en(circ_eff),
    .prog(base_n), .live(remaining), .zero(cnt_zero), .hit_half(hit_half),
    .hit_done(hit_done), .wrap(wrap));

  dma_width_adapt #(.DW(DW)) u_adapt (
    .rd_item(rd_hold), .src_size(src_sz), .dst_size(dst_sz), .wr_bus(adapted));

  assign bus_valid = (state != ST_IDLE);
  assign bus_write = (state == ST_WR);
  assign bus_size  = bus_write ? dst_sz : src_sz;
  assign bus_addr  = (bus_write ^ cfg_dir) ? m_addr : p_addr;
  assign bus_wdata = bus_write ? adapted : '0;
  assign chan_en   = en_q;

  p_err_disables_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_err) |=> (!chan_en && evt_err));

  p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_write && !bus_err) |=> (bus_valid && bus_write));

  p_hold_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)
                                   && $stable(bus_size) && $stable(bus_wdata)));

  p_base_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> ($stable(base_p) && $stable(base_m) && $stable(base_n)));

  p_done_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done && !circ_eff) |-> (remaining == '0));

  p_half_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_half |=> !evt_half);
endmodule

// File: tb/tb_dma_xfer_engine.sv
module tb_dma_xfer_engine;
  localparam int TCLK = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_wr = 1'b0, en_wdata = 1'b0, prog_we = 1'b0;
  logic [31:0] prog_paddr = '0, prog_maddr = '0;
  logic [15:0] prog_count = '0;
  logic        cfg_dir = 1'b0, cfg_circ = 1'b0, cfg_m2m = 1'b0;
  logic [1:0]  cfg_psize = '0, cfg_msize = '0;
  logic        cfg_pinc = 1'b0, cfg_minc = 1'b0, xfer_req = 1'b0;
  logic        bus_valid, bus_write;
  logic [31:0] bus_addr, bus_wdata;
  logic [1:0]  bus_size;
  logic        bus_ready = 1'b0, bus_err = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        chan_en, evt_half, evt_done, evt_err;
  logic [15:0] remaining;

  always #(TCLK/2) clk = ~clk;

  dma_xfer_engine dut (.*);

  int vec = 0, bad = 0, items = 0;
  bit finished = 0;

  // Bench model of the channel.
  bit          e_en, e_circ, e_m2m, e_dir, e_pinc, e_minc;
  logic [1:0]  e_ps, e_ms;
  logic [31:0] e_pb, e_mb, e_p, e_m, last_rd;
  logic [15:0] e_n, e_left;
  bit          pend_h, pend_d, pend_e, pend_rem;
  bit          poison_on = 0;
  logic [31:0] poison = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int fbytes(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] falign(input logic [31:0] a, input logic [1:0] s);
    if (s == 2'b00) return a;
    if (s == 2'b01) return {a[31:1], 1'b0};
    return {a[31:2], 2'b00};
  endfunction

  function automatic logic [31:0] fadapt(input logic [31:0] rd, input logic [1:0] ss, input logic [1:0] ds);
    int w;
    logic [31:0] v;
    w = (fbytes(ss) < fbytes(ds)) ? fbytes(ss) : fbytes(ds);
    v = (w == 1) ? {24'h0, rd[7:0]} : (w == 2) ? {16'h0, rd[15:0]} : rd;
    if (ds == 2'b00) return {4{v[7:0]}};
    if (ds == 2'b01) return {2{v[15:0]}};
    return v;
  endfunction

  function automatic logic [31:0] frd(input logic [31:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] ^ 8'h5A, a[23:16] + 8'h11, a[31:24] ^ a[7:0] ^ 8'h96};
  endfunction

  // Bus slave and monitor.
  initial begin
    logic [1:0]  ss, ds;
    logic [31:0] sraw, draw, rd;
    bit          er;
    forever begin
      @(negedge clk);
      if (pend_h || pend_d || pend_e || evt_half || evt_done || evt_err) begin
        chk("R11 half event", 32'(evt_half), 32'(pend_h));
        chk("R11 done event", 32'(evt_done), 32'(pend_d));
        chk("R12 error event", 32'(evt_err), 32'(pend_e));
      end
      if (pend_e) chk("R12 enable cleared", 32'(chan_en), 32'd0);
      if (pend_rem) chk("R7 remaining after item", 32'(remaining), 32'(e_left));
      pend_h = 0; pend_d = 0; pend_e = 0; pend_rem = 0;
      bus_ready = 1'b0; bus_err = 1'b0;
      if (bus_valid && ($urandom % 4 != 0)) begin
        bus_ready = 1'b1;
        ss   = e_dir ? e_ms : e_ps;
        ds   = e_dir ? e_ps : e_ms;
        sraw = e_dir ? e_m : e_p;
        draw = e_dir ? e_p : e_m;
        if (!bus_write) begin
          chk("R2 access only when enabled with items", 32'(e_en && e_left != 0), 32'd1);
          chk("R3 R4 read address", bus_addr, falign(sraw, ss));
          chk("R4 read size", 32'(bus_size), 32'(ss));
          rd = frd(bus_addr);
          bus_rdata = rd;
          er = poison_on && (bus_addr == poison);
          bus_err = er;
          if (er) begin pend_e = 1; e_en = 0; end
          else last_rd = rd;
        end else begin
          chk("R3 R4 write address", bus_addr, falign(draw, ds));
          chk("R4 write size", 32'(bus_size), 32'(ds));
          chk("R6 write data", bus_wdata, fadapt(last_rd, ss, ds));
          er = poison_on && (bus_addr == poison);
          bus_err = er;
          if (er) begin pend_e = 1; e_en = 0; end
          else begin
            e_left = e_left - 1'b1;
            items++;
            pend_rem = 1;
            pend_h = (e_left == (e_n >> 1));
            pend_d = (e_left == 0);
            if (e_pinc) e_p = e_p + 32'(fbytes(e_ps));   // R5
            if (e_minc) e_m = e_m + 32'(fbytes(e_ms));
            if (e_left == 0 && e_circ && !e_m2m) begin    // R8
              e_left = e_n; e_p = e_pb; e_m = e_mb;
            end
          end
        end
      end
    end
  end

  task automatic configure(input bit dir, input bit circ, input bit m2m, input logic [1:0] ps,
                           input logic [1:0] ms, input bit pi, input bit mi,
                           input logic [31:0] pa, input logic [31:0] ma, input logic [15:0] n);
    @(negedge clk);
    cfg_dir = dir; cfg_circ = circ; cfg_m2m = m2m; cfg_psize = ps; cfg_msize = ms;
    cfg_pinc = pi; cfg_minc = mi;
    prog_paddr = pa; prog_maddr = ma; prog_count = n; prog_we = 1'b1;
    e_dir = dir; e_circ = circ; e_m2m = m2m; e_ps = ps; e_ms = ms; e_pinc = pi; e_minc = mi;
    e_pb = pa; e_mb = ma; e_n = n;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic set_enable(input bit v);
    @(negedge clk);
    en_wr = 1'b1; en_wdata = v;
    if (v && !e_en) begin e_p = e_pb; e_m = e_mb; e_left = e_n; end
    e_en = v;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  task automatic wait_quiet();
    int n;
    n = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if ((e_left == 0 || !e_en || !(xfer_req || e_m2m)) && !bus_valid) n++;
      else n = 0;
      if (n >= 3) break;
    end
    if (n < 3) chk("R7 transfer finished in time", 32'd0, 32'd1);
  endtask

  task automatic wait_items(input int target);
    for (int c = 0; c < 3000 && items < target; c++) @(negedge clk);
    chk("R8 circular service continues", 32'(items >= target), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vec++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5a));
    e_en = 0; e_left = 0; e_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 enable after reset", 32'(chan_en), 32'd0);
    chk("R1 bus idle after reset", 32'(bus_valid), 32'd0);
    chk("R1 remaining after reset", 32'(remaining), 32'd0);
    chk("R1 events after reset", 32'({evt_half, evt_done, evt_err}), 32'd0);

    // Zero-extension 8 -> 32, memory-to-memory, unaligned memory base.
    configure(0, 0, 1, 2'b00, 2'b10, 1, 1, 32'h1000_0003, 32'h2000_0002, 16'd4);
    set_enable(1);
    wait_quiet();
    chk("R7 count stops at zero", 32'(remaining), 32'd0);
    chk("R7 enable stays set", 32'(chan_en), 32'd1);
    repeat (6) begin @(negedge clk); chk("R7 no access after zero", 32'(bus_valid), 32'd0); end
    set_enable(0);

    // Truncation 32 -> 16, memory to peripheral, fixed peripheral address.
    configure(1, 0, 0, 2'b01, 2'b10, 0, 1, 32'h4000_0106, 32'h2000_1000, 16'd5);
    set_enable(1);
    repeat (8) begin @(negedge clk); chk("R2 no request no access", 32'(bus_valid), 32'd0); end
    xfer_req = 1'b1;
    wait_quiet();
    xfer_req = 1'b0;
    chk("R7 count at zero", 32'(remaining), 32'd0);
    set_enable(0);

    // Circular 16 -> 16 with reload across several laps.
    configure(0, 1, 0, 2'b01, 2'b01, 1, 1, 32'h4000_0200, 32'h2000_2001, 16'd3);
    items = 0;
    set_enable(1);
    xfer_req = 1'b1;
    wait_items(8);
    xfer_req = 1'b0;
    wait_quiet();
    chk("R8 enable stays set in circular", 32'(chan_en), 32'd1);
    set_enable(0);
    set_enable(1);
    chk("R10 R8 count reloaded from kept value", 32'(remaining), 32'd3);
    items = 0;
    xfer_req = 1'b1;
    wait_items(2);
    xfer_req = 1'b0;
    wait_quiet();
    set_enable(0);

    // Memory-to-memory ignores circular.
    configure(0, 1, 1, 2'b10, 2'b00, 1, 1, 32'h3000_0000, 32'h2000_3000, 16'd3);
    set_enable(1);
    wait_quiet();
    repeat (5) @(negedge clk);
    chk("R9 m2m stops at zero", 32'(remaining), 32'd0);
    chk("R9 bus idle", 32'(bus_valid), 32'd0);
    set_enable(0);

    // Read error.
    poison_on = 1; poison = 32'h4000_0300;
    configure(0, 0, 1, 2'b10, 2'b10, 1, 1, 32'h4000_0300, 32'h2000_4000, 16'd4);
    set_enable(1);
    wait_quiet();
    chk("R12 read error clears enable", 32'(chan_en), 32'd0);
    chk("R12 read error not counted", 32'(remaining), 32'd4);
    // Write error on the second item.
    poison = 32'h2000_5004;
    configure(0, 0, 1, 2'b10, 2'b10, 1, 1, 32'h4000_0400, 32'h2000_5000, 16'd4);
    set_enable(1);
    wait_quiet();
    chk("R12 write error clears enable", 32'(chan_en), 32'd0);
    chk("R12 write error not counted", 32'(remaining), 32'd3);
    poison_on = 0;
    e_en = 0;
    set_enable(0);

    // Programming ignored while enabled.
    configure(0, 0, 0, 2'b00, 2'b00, 1, 1, 32'h4000_0500, 32'h2000_6000, 16'd3);
    set_enable(1);
    @(negedge clk);
    prog_count = 16'd9; prog_we = 1'b1;
    @(negedge clk);
    prog_we = 1'b0;
    set_enable(0);
    set_enable(1);
    chk("R10 write while enabled ignored", 32'(remaining), 32'd3);
    set_enable(0);
    configure(0, 0, 0, 2'b00, 2'b00, 1, 1, 32'h4000_0500, 32'h2000_6000, 16'd5);
    set_enable(1);
    chk("R10 enable edge loads new count", 32'(remaining), 32'd5);
    set_enable(0);

    // Random configurations, half/done for N=1 included.
    for (int k = 0; k < 40; k++) begin
      configure(1'($urandom), 1'($urandom), 1, 2'($urandom % 3), 2'($urandom % 3),
                1'($urandom), 1'($urandom), $urandom, $urandom, 16'(1 + $urandom % 6));
      set_enable(1);
      wait_quiet();
      chk("R7 random run ends at zero", 32'(remaining), 32'd0);
      set_enable(0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule